// File: doc/BRIEF.md
# Soft-Start Reference Sequencer

This block steps the reference code of a switching regulator from zero up to a programmed target after the converter is allowed to start. It runs on the system clock. A one-clock pulse marks each switching period, and the sequence advances only on those pulses. Two status inputs gate the start: the enable comparator and the driver-bias power-on reset. A comparator flag tells the sequencer whether the sensed output is still above the ramping reference.

After a fixed wait, the reference rises at a constant slope of 1280 switching periods per volt. The code is counted in 12.5 mV units. For the early part of the ramp the code rises in 2-code steps, and after that it rises in 1-code steps. While the early part runs, a small remote-sense offset code winds down from its starting value to zero.

The power drivers stay high-impedance while the output sits above the ramp. This lets the converter start into a pre-charged output without pulling current from it. If the output never drops below the ramp, the drivers are released when the ramp completes. Losing either start condition returns the block to shutdown at once.

Top module: `softstart_seq`

## Requirements
- R1: While `en_ok` and `bias_ok` are both high, the sequence runs. If either input is low at a clock edge, the next cycle shows `dac_code`=0, `ofs_code`=8, `drv_en`=0 and `ss_done`=0.
- R2: The first clock with both start inputs high arms the sequencer, and this clock does not count as a period. During the next 64 `tick` pulses, `dac_code` stays 0 and `ofs_code` stays 8.
- R3: For the first 640 ticks after the wait, `dac_code` rises by 2 on every 32nd tick. It changes on no other clock.
- R4: After those 640 ticks, `dac_code` rises by 1 on every 16th tick.
- R5: `dac_code` never goes past `target`. A step that would overshoot lands exactly on `target`.
- R6: `ofs_code` starts at 8 and drops by 1 on every 80th tick of the coarse window. It reaches 0 at the end of that window and then stays at 0.
- R7: `drv_en` rises one clock after a clock edge where the ramp is active and `fb_above` is low. It stays high until shutdown. It is never high during the wait.
- R8: If `fb_above` stays high for the whole ramp, `drv_en` rises in the same cycle as `ss_done`.
- R9: `ss_done` rises in the cycle where `dac_code` first equals `target` once the ramp has begun, which includes right at the end of the wait when `target` is 0. After that, both `ss_done` and `dac_code` hold and further ticks are ignored until shutdown.
- R10: A restart after shutdown goes through the full 64-tick wait again, starting from code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_ok | input | 1 | Enable comparator reports its input above threshold |
| bias_ok | input | 1 | Driver-bias power-on reset satisfied |
| tick | input | 1 | One-clock pulse per switching period |
| fb_above | input | 1 | Sensed output is above the ramping reference |
| target | input | 8 | Final reference code, in 12.5 mV units |
| dac_code | output | 8 | Reference code, in 12.5 mV units |
| ofs_code | output | 4 | Remote-sense offset code, in 12.5 mV units |
| drv_en | output | 1 | Drivers active; high-impedance while low |
| ss_done | output | 1 | Ramp has reached the target |

## Verification
Two events can land on the same clock. One is the final code step that reaches the target. The other is the forced driver release for an output that was pre-charged above the target. The bench sets up this case by holding `fb_above` high for a whole run. It then checks that `drv_en` and `ss_done` rise together and not one cycle apart.

A second same-cycle case happens at the 640-tick boundary. On that tick a coarse step, the last offset decrement and the switch to fine steps all fall together. This is tested with a target of exactly 40, which finishes the ramp on that boundary tick. It is also covered by random targets whose ramps run past the boundary.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_DELAY  = 2'd1,
        PH_COARSE = 2'd2,
        PH_FINE   = 2'd3
    } ssq_phase_e;
endpackage

// File: rtl/ssq_phase_ctl.sv
module ssq_phase_ctl
    import ssq_pkg::*;
#(
    parameter int DELAY_TICKS  = 64,
    parameter int COARSE_TICKS = 640,
    parameter int COARSE_DIV   = 32,
    parameter int FINE_DIV     = 16,
    parameter int OFS_DIV      = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic halt,
    output logic ramping,
    output logic ramp_start,
    output logic step_big,
    output logic step_small,
    output logic ofs_dec
);
    localparam int SPAN   = (DELAY_TICKS > COARSE_TICKS) ? DELAY_TICKS : COARSE_TICKS;
    localparam int CNT_W  = $clog2(SPAN + 1);
    localparam int DIVMX  = (COARSE_DIV > FINE_DIV) ? COARSE_DIV : FINE_DIV;
    localparam int DIV_W  = $clog2(DIVMX + 1);
    localparam int OCNT_W = $clog2(OFS_DIV + 1);

    localparam logic [CNT_W-1:0]  DLY_LAST = CNT_W'(DELAY_TICKS - 1);
    localparam logic [CNT_W-1:0]  CRS_LAST = CNT_W'(COARSE_TICKS - 1);
    localparam logic [DIV_W-1:0]  CDV_LAST = DIV_W'(COARSE_DIV - 1);
    localparam logic [DIV_W-1:0]  FDV_LAST = DIV_W'(FINE_DIV - 1);
    localparam logic [OCNT_W-1:0] ODV_LAST = OCNT_W'(OFS_DIV - 1);

    typedef struct packed {
        ssq_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        logic [DIV_W-1:0]  div;
        logic [OCNT_W-1:0] ocnt;
    } ctl_t;

    ctl_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        ramp_start = 1'b0;
        step_big   = 1'b0;
        step_small = 1'b0;
        ofs_dec    = 1'b0;
        if (!run) begin
            st_d = '{phase: PH_OFF, cnt: '0, div: '0, ocnt: '0};
        end else begin
            unique case (st_q.phase)
                PH_OFF: begin
                    st_d.phase = PH_DELAY;
                    st_d.cnt   = '0;
                end
                PH_DELAY: begin
                    if (tick) begin
                        if (st_q.cnt == DLY_LAST) begin
                            st_d.phase = PH_COARSE;
                            st_d.cnt   = '0;
                            st_d.div   = '0;
                            st_d.ocnt  = '0;
                            ramp_start = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_COARSE: begin
                    if (tick && !halt) begin
                        if (st_q.div == CDV_LAST) begin
                            st_d.div = '0;
                            step_big = 1'b1;
                        end else begin
                            st_d.div = st_q.div + 1'b1;
                        end
                        if (st_q.ocnt == ODV_LAST) begin
                            st_d.ocnt = '0;
                            ofs_dec   = 1'b1;
                        end else begin
                            st_d.ocnt = st_q.ocnt + 1'b1;
                        end
                        if (st_q.cnt == CRS_LAST) begin
                            st_d.phase = PH_FINE;
                            st_d.cnt   = '0;
                            st_d.div   = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_FINE: begin
                    if (tick && !halt) begin
                        if (st_q.div == FDV_LAST) begin
                            st_d.div   = '0;
                            step_small = 1'b1;
                        end else begin
                            st_d.div = st_q.div + 1'b1;
                        end
                    end
                end
                default: st_d.phase = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_OFF, cnt: '0, div: '0, ocnt: '0};
        else        st_q <= st_d;
    end

    assign ramping = (st_q.phase == PH_COARSE) || (st_q.phase == PH_FINE);
endmodule

// File: rtl/ssq_ramp.sv
module ssq_ramp #(
    parameter int CODE_W     = 8,
    parameter int BIG_STEP   = 2,
    parameter int SMALL_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ramping,
    input  logic              ramp_start,
    input  logic              step_big,
    input  logic              step_small,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] code,
    output logic              done_q,
    output logic              done_next
);
    localparam logic [CODE_W:0] INC_BIG   = (CODE_W+1)'(BIG_STEP);
    localparam logic [CODE_W:0] INC_SMALL = (CODE_W+1)'(SMALL_STEP);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              done;
    } ramp_t;

    ramp_t r_q, r_d;
    logic [CODE_W:0] inc;
    logic [CODE_W:0] sum;

    always_comb begin
        r_d = r_q;
        inc = step_big ? INC_BIG : (step_small ? INC_SMALL : '0);
        sum = {1'b0, r_q.code} + inc;
        if (!run) begin
            r_d = '{code: '0, done: 1'b0};
        end else if (!r_q.done) begin
            if (sum > {1'b0, target}) r_d.code = target;
            else                      r_d.code = sum[CODE_W-1:0];
            if ((ramping || ramp_start) && (r_d.code == target)) r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{code: '0, done: 1'b0};
        else        r_q <= r_d;
    end

    assign code      = r_q.code;
    assign done_q    = r_q.done;
    assign done_next = r_d.done;
endmodule

// File: rtl/ssq_offset.sv
module ssq_offset #(
    parameter int OFS_W    = 4,
    parameter int OFS_INIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dec,
    output logic [OFS_W-1:0] ofs
);
    localparam logic [OFS_W-1:0] START = OFS_W'(OFS_INIT);

    typedef struct packed {
        logic [OFS_W-1:0] val;
    } ofs_t;

    ofs_t o_q, o_d;

    always_comb begin
        o_d = o_q;
        if (!run)                       o_d.val = START;
        else if (dec && o_q.val != '0)  o_d.val = o_q.val - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q.val <= START;
        else        o_q <= o_d;
    end

    assign ofs = o_q.val;
endmodule

// File: rtl/ssq_drv_gate.sv
module ssq_drv_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ramping,
    input  logic fb_above,
    input  logic done_next,
    output logic drv_en
);
    typedef struct packed {
        logic en;
    } gate_t;

    gate_t g_q, g_d;

    always_comb begin
        g_d = g_q;
        if (!run) g_d.en = 1'b0;
        else      g_d.en = g_q.en || done_next || (ramping && !fb_above);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q.en <= 1'b0;
        else        g_q <= g_d;
    end

    assign drv_en = g_q.en;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
    parameter int CODE_W       = 8,
    parameter int OFS_W        = 4,
    parameter int OFS_INIT     = 8,
    parameter int DELAY_TICKS  = 64,
    parameter int COARSE_TICKS = 640,
    parameter int COARSE_DIV   = 32,
    parameter int FINE_DIV     = 16,
    parameter int OFS_DIV      = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_ok,
    input  logic              bias_ok,
    input  logic              tick,
    input  logic              fb_above,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] dac_code,
    output logic [OFS_W-1:0]  ofs_code,
    output logic              drv_en,
    output logic              ss_done
);
    logic run;
    logic ramping, ramp_start, step_big, step_small, ofs_dec;
    logic done_q, done_next;

    assign run = en_ok && bias_ok;

    ssq_phase_ctl #(
        .DELAY_TICKS (DELAY_TICKS),
        .COARSE_TICKS(COARSE_TICKS),
        .COARSE_DIV  (COARSE_DIV),
        .FINE_DIV    (FINE_DIV),
        .OFS_DIV     (OFS_DIV)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .halt      (done_q),
        .ramping   (ramping),
        .ramp_start(ramp_start),
        .step_big  (step_big),
        .step_small(step_small),
        .ofs_dec   (ofs_dec)
    );

    ssq_ramp #(
        .CODE_W    (CODE_W),
        .BIG_STEP  (2),
        .SMALL_STEP(1)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .ramping   (ramping),
        .ramp_start(ramp_start),
        .step_big  (step_big),
        .step_small(step_small),
        .target    (target),
        .code      (dac_code),
        .done_q    (done_q),
        .done_next (done_next)
    );

    ssq_offset #(
        .OFS_W   (OFS_W),
        .OFS_INIT(OFS_INIT)
    ) u_ofs (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .dec  (ofs_dec),
        .ofs  (ofs_code)
    );

    ssq_drv_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ramping  (ramping),
        .fb_above (fb_above),
        .done_next(done_next),
        .drv_en   (drv_en)
    );

    assign ss_done = done_q;
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
    parameter int CODE_W   = 8,
    parameter int OFS_W    = 4,
    parameter int OFS_INIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_ok,
    input logic              bias_ok,
    input logic              tick,
    input logic [CODE_W-1:0] target,
    input logic [CODE_W-1:0] dac_code,
    input logic [OFS_W-1:0]  ofs_code,
    input logic              drv_en,
    input logic              ss_done
);
    logic go;
    assign go = en_ok && bias_ok;

    AST_SHUTDOWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (dac_code == '0 && ofs_code == OFS_W'(OFS_INIT) && !drv_en && !ss_done)); // R1
    AST_CODE_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !tick) |=> $stable(dac_code)); // R3
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (int'(dac_code) >= int'($past(dac_code)) && int'(dac_code) <= int'($past(dac_code)) + 2)); // R4
    AST_CODE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $stable(target) && dac_code <= target) |=> dac_code <= target); // R5
    AST_OFS_NONRISE: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> ofs_code <= $past(ofs_code)); // R6
    AST_DRV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (go && drv_en) |=> drv_en); // R7
    AST_DONE_WITH_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> drv_en); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ss_done) |=> (ss_done && $stable(dac_code))); // R9
endmodule

bind softstart_seq ssq_checker #(
    .CODE_W  (CODE_W),
    .OFS_W   (OFS_W),
    .OFS_INIT(OFS_INIT)
) u_ssq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_ok   (en_ok),
    .bias_ok (bias_ok),
    .tick    (tick),
    .target  (target),
    .dac_code(dac_code),
    .ofs_code(ofs_code),
    .drv_en  (drv_en),
    .ss_done (ss_done)
);

// File: tb/softstart_seq_test.sv
module softstart_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_ok = 1'b0, bias_ok = 1'b0, tick = 1'b0, fb_above = 1'b0;
    logic [7:0] target = 8'd0;
    logic [7:0] dac_code;
    logic [3:0] ofs_code;
    logic       drv_en, ss_done;

    int checks = 0, errors = 0;
    int seed_v;

    // bench model state
    int  m_n = 0;
    bit  m_act = 0, m_drv = 0, m_done = 0;
    int  pre_lvl = 0;

    always #4 clk = ~clk;

    softstart_seq uut (
        .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .bias_ok(bias_ok),
        .tick(tick), .fb_above(fb_above), .target(target),
        .dac_code(dac_code), .ofs_code(ofs_code), .drv_en(drv_en), .ss_done(ss_done)
    );

    function automatic int f_code(int n, int tg);
        int k, c;
        k = n - 64;
        if (k < 0)        c = 0;
        else if (k <= 640) c = 2 * (k / 32);
        else              c = 40 + (k - 640) / 16;
        return (c > tg) ? tg : c;
    endfunction

    function automatic int f_ofs(int n);
        int k;
        k = n - 64;
        if (k <= 0)  return 8;
        if (k >= 640) return 0;
        return 8 - k / 80;
    endfunction

    task automatic chk(string tag, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp_v, $time);
        end
    endtask

    task automatic check_all();
        int ec;
        string ct;
        ec = (m_act) ? f_code(m_n, int'(target)) : 0;
        if (!m_act)                   ct = "R1 code";
        else if (m_n < 64)            ct = "R2 code";
        else if (ec == int'(target))  ct = "R5 code";
        else if (m_n - 64 < 640)      ct = "R3 code";
        else                          ct = "R4 code";
        chk(ct, int'(dac_code), ec);
        chk("R6 offset", int'(ofs_code), m_act ? f_ofs(m_n) : 8);
        chk("R7 drv_en", int'(drv_en), int'(m_drv));
        chk("R9 done", int'(ss_done), int'(m_done));
    endtask

    // drive one cycle at the negedge, advance model, check after the edge
    task automatic cyc(bit e, bit b, bit t);
        bit run, ramp_before, above;
        int cur;
        cur   = m_act ? f_code(m_n, int'(target)) : 0;
        above = (cur < pre_lvl);
        en_ok = e; bias_ok = b; tick = t; fb_above = above;
        run = e && b;
        if (!run) begin
            m_n = 0; m_act = 0; m_drv = 0; m_done = 0;
        end else if (!m_act) begin
            m_act = 1; m_n = 0;
        end else begin
            ramp_before = (m_n >= 64) && !m_done;
            if (t && !m_done) m_n++;
            if (m_n >= 64 && f_code(m_n, int'(target)) == int'(target)) m_done = 1;
            m_drv = m_drv || m_done || (ramp_before && !above);
        end
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic run_seq(int tg, int pre, int max_cyc, int drop_at);
        target  = 8'(tg);
        pre_lvl = pre;
        for (int i = 0; i < max_cyc; i++) begin
            bit tk;
            if (i == drop_at) begin
                cyc(1'b0, 1'b1, 1'b1);
                break;
            end
            tk = ($urandom % 3) != 0;
            cyc(1'b1, 1'b1, tk);
            if (m_done && i > 4) begin
                for (int j = 0; j < 40; j++) cyc(1'b1, 1'b1, 1'b1); // R9 ticks ignored
                break;
            end
        end
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        seed_v = $urandom(32'h5eed_17);
        #(3000000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset code", int'(dac_code), 0);
        chk("R1 reset offset", int'(ofs_code), 8);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: early drop in coarse, then R10 restart with full wait
        run_seq(96, 20, 400, 300);
        target = 8'd96;
        cyc(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 63; i++) cyc(1'b1, 1'b1, 1'b1);
        chk("R10 still waiting", int'(dac_code), 0);
        chk("R10 offset held", int'(ofs_code), 8);
        cyc(1'b1, 1'b0, 1'b1); // bias drop R1
        chk("R1 bias drop", int'(drv_en), 0);

        // R8: pre-charged above target, drv_en and done together
        run_seq(40, 255, 5000, -1);
        // pre-charge at zero: drivers on right at ramp start (R7)
        run_seq(30, 0, 5000, -1);
        // R9: target zero finishes at end of wait
        run_seq(0, 0, 500, -1);
        // full 1.2 V example and extended fine phase (R4)
        run_seq(96, 50, 8000, -1);
        run_seq(150, 255, 12000, -1);
        // directed R8 same-cycle check
        target = 8'd12; pre_lvl = 255;
        cyc(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 64 + 6 * 32 - 1; i++) cyc(1'b1, 1'b1, 1'b1);
        chk("R8 drv before final step", int'(drv_en), 0);
        cyc(1'b1, 1'b1, 1'b1);
        chk("R8 drv with done", int'(drv_en), 1);
        chk("R8 done", int'(ss_done), 1);
        cyc(1'b0, 1'b0, 1'b0);
        // random targets
        for (int r = 0; r < 4; r++) begin
            run_seq(1 + int'($urandom % 120), int'($urandom % 140), 9000,
                    (r == 2) ? 900 : -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule